// File: doc/BRIEF.md
# Privileged-Mode Exception Entry Unit

This unit steers a 64-bit core into its privileged firmware mode when an exception or interrupt has been accepted. For each accepted code it works out the firmware entry address, the return address to save and the mode change. When the core enters from normal mode, it also exchanges eight architectural integer registers with a private shadow bank. Instruction fetch, pipeline flushing and the choice between competing exceptions belong to other blocks.

Entry codes form two tables of 64 slots, with 64 bytes per slot. Codes with bit 7 clear are privileged entries, placed from offset 0. Codes with bit 7 set are unprivileged entries, placed from offset 0x2000. The unit drives write enables and write data toward the owners of the PC, the saved-address register, the mode bit and the register file, so that every update lands on the same clock edge. The register file gives the unit one parallel read port and one parallel write port, covering all eight swapped registers. The shadow bank is held inside the unit.

Top module: `priv_entry_unit`

## Requirements
- R1: For an accepted code with bit 7 = 0 and bit 6 = 0, `pc_we_o` is high and `pc_wdata_o` = `base_i` + code[5:0]×64.
- R2: For an accepted code with bit 7 = 1 and bit 6 = 0, `pc_wdata_o` = `base_i` + 0x2000 + code[5:0]×64.
- R3: For a valid accept, `exc_addr_we_o` is high and `exc_addr_o` = `pc_i` with bit 0 ORed with `mode_i`.
- R4: For a valid accept with `mode_i` = 0, `mode_set_o` and `arch_we_o` are high, lane k of `arch_wdata_o` equals shadow entry k, and at that clock edge shadow entry k loads lane k of `arch_rdata_i`. Lane k occupies bits [64k+63:64k].
- R5: For a valid accept with `mode_i` = 1, `mode_set_o` and `arch_we_o` stay low and the shadow bank keeps its contents.
- R6: A code with bit 6 = 1 raises `abort_o` while it is accepted. It drives no PC, saved-address, mode or register write, does not clear the pending code, and leaves the shadow bank unchanged.
- R7: `exc_clear_o` is high exactly when a valid accept is presented.
- R8: `swap_idx_o` gives 5-bit register numbers per lane: lanes 0 to 6 map to registers 8 to 14 and lane 7 maps to register 25.
- R9: With `accept_i` low, every write enable, `abort_o` and `exc_clear_o` are low.
- R10: After reset, every shadow entry holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| accept_i | input | 1 | Single-cycle strobe: an exception is accepted this cycle |
| code_i | input | 8 | Exception code |
| pc_i | input | 64 | Current PC |
| mode_i | input | 1 | Current privileged-mode bit |
| base_i | input | 64 | Firmware base address |
| arch_rdata_i | input | 512 | Read port: eight swapped registers, lane order |
| pc_we_o | output | 1 | PC write enable |
| pc_wdata_o | output | 64 | Entry address |
| exc_addr_we_o | output | 1 | Saved-address write enable |
| exc_addr_o | output | 64 | Return address tagged with mode |
| mode_set_o | output | 1 | Set privileged mode |
| exc_clear_o | output | 1 | Clear pending exception code |
| abort_o | output | 1 | Unknown code accepted |
| arch_we_o | output | 1 | Register-file swap write enable |
| arch_wdata_o | output | 512 | Write data per lane from the shadow bank |
| swap_idx_o | output | 40 | Register number of each lane |

## Verification
The bench probes the edges of both tables (codes 0x00, 0x3F, 0x80, 0xBF) and the unknown codes 0x40 and 0xC0. A decoder that ignores bit 6 would send those unknown codes to a real entry, and a wrong unprivileged base or slot width would land one slot or one table away. It runs several swaps in a row from normal mode, with privileged-mode and aborted accepts placed between them. Each swap's write data must then equal the register contents captured by the previous valid normal-mode swap. A bank that also swapped while already privileged, or that loaded on an abort, would return the wrong pattern. It also checks that the saved address carries the mode only in bit 0 and that the register lanes appear in the stated order.

// File: rtl/pentry_pkg.sv
package pentry_pkg;
  localparam int unsigned REG_IDX_W  = 5;
  localparam int unsigned LOW_REG    = 8;
  localparam int unsigned TOP_REG    = 25;

  typedef enum logic [1:0] {
    VEC_PRIV   = 2'd0,
    VEC_UNPRIV = 2'd1,
    VEC_BAD    = 2'd2
  } vec_kind_e;

  // last lane goes to the high register, the rest are contiguous
  function automatic logic [REG_IDX_W-1:0] lane_reg(int unsigned lane, int unsigned lanes);
    if (lane == lanes - 1) return REG_IDX_W'(TOP_REG);
    return REG_IDX_W'(LOW_REG + lane);
  endfunction
endpackage

// File: rtl/pentry_vector.sv
module pentry_vector
  import pentry_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned ENTRIES    = 64,
  parameter int unsigned SLOT_BYTES = 64,
  parameter int unsigned UNPRIV_OFS = 32'h2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output vec_kind_e         kind_o,
  output logic [XLEN-1:0]   offset_o
);
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned SLOT_SH = $clog2(SLOT_BYTES);
  localparam int unsigned SEL_BIT = CODE_W - 1;

  logic            bad;
  logic            unpriv;
  logic [XLEN-1:0] slot_ofs;

  generate
    if (SEL_BIT > IDX_W) begin : g_gap
      assign bad = |code_i[SEL_BIT-1:IDX_W];
    end else begin : g_nogap
      assign bad = 1'b0;
    end
  endgenerate

  assign unpriv   = code_i[SEL_BIT];
  assign slot_ofs = XLEN'(code_i[IDX_W-1:0]) << SLOT_SH;

  always_comb begin
    if (bad)         kind_o = VEC_BAD;
    else if (unpriv) kind_o = VEC_UNPRIV;
    else             kind_o = VEC_PRIV;
  end

  assign offset_o = unpriv ? slot_ofs + XLEN'(UNPRIV_OFS) : slot_ofs;

  AST_UNPRIV_ABOVE_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == VEC_UNPRIV) |-> (offset_o >= XLEN'(UNPRIV_OFS))); // R2
  AST_PRIV_BELOW_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == VEC_PRIV) |-> (offset_o < XLEN'(UNPRIV_OFS))); // R1
endmodule

// File: rtl/pentry_shadow_bank.sv
module pentry_shadow_bank #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LANES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  swap_i,
  input  logic [LANES*XLEN-1:0] load_i,
  output logic [LANES*XLEN-1:0] shadow_o
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (swap_i) q <= load_i[k*XLEN +: XLEN];
      end
      assign shadow_o[k*XLEN +: XLEN] = q;
    end
  endgenerate

  AST_SHADOW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> (shadow_o == $past(load_i))); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i |=> $stable(shadow_o)); // R5
endmodule

// File: rtl/pentry_commit.sv
module pentry_commit
  import pentry_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned SLOT_BYTES = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  vec_kind_e       kind_i,
  input  logic [XLEN-1:0] offset_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            mode_i,
  output logic            pc_we_o,
  output logic [XLEN-1:0] pc_wdata_o,
  output logic            exc_addr_we_o,
  output logic [XLEN-1:0] exc_addr_o,
  output logic            mode_set_o,
  output logic            swap_o,
  output logic            exc_clear_o,
  output logic            abort_o
);
  localparam logic [XLEN-1:0] SLOT_MASK = XLEN'(SLOT_BYTES - 1);

  logic take;
  assign take = accept_i && (kind_i != VEC_BAD);

  assign pc_we_o       = take;
  assign pc_wdata_o    = base_i + offset_i;
  assign exc_addr_we_o = take;
  assign exc_addr_o    = pc_i | {{(XLEN-1){1'b0}}, mode_i};
  assign mode_set_o    = take && !mode_i;
  assign swap_o        = take && !mode_i;
  assign exc_clear_o   = take;
  assign abort_o       = accept_i && (kind_i == VEC_BAD);

  AST_VEC_SLOT_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> (((pc_wdata_o - base_i) & SLOT_MASK) == '0)); // R1
  AST_SAVED_MODE_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_addr_we_o && mode_i) |-> exc_addr_o[0]); // R3
  AST_NO_SWAP_IN_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_o |-> !mode_i); // R5
  AST_ABORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!pc_we_o && !swap_o && !exc_clear_o && !exc_addr_we_o)); // R6
  AST_CLEAR_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_clear_o |-> accept_i); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |-> (!pc_we_o && !mode_set_o && !abort_o && !exc_clear_o)); // R9
endmodule

// File: rtl/priv_entry_unit.sv
module priv_entry_unit
  import pentry_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned ENTRIES    = 64,
  parameter int unsigned SLOT_BYTES = 64,
  parameter int unsigned UNPRIV_OFS = 32'h2000,
  parameter int unsigned LANES      = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        accept_i,
  input  logic [CODE_W-1:0]           code_i,
  input  logic [XLEN-1:0]             pc_i,
  input  logic                        mode_i,
  input  logic [XLEN-1:0]             base_i,
  input  logic [LANES*XLEN-1:0]       arch_rdata_i,
  output logic                        pc_we_o,
  output logic [XLEN-1:0]             pc_wdata_o,
  output logic                        exc_addr_we_o,
  output logic [XLEN-1:0]             exc_addr_o,
  output logic                        mode_set_o,
  output logic                        exc_clear_o,
  output logic                        abort_o,
  output logic                        arch_we_o,
  output logic [LANES*XLEN-1:0]       arch_wdata_o,
  output logic [LANES*REG_IDX_W-1:0]  swap_idx_o
);
  vec_kind_e       kind;
  logic [XLEN-1:0] offset;
  logic            swap;

  pentry_vector #(
    .XLEN(XLEN), .CODE_W(CODE_W), .ENTRIES(ENTRIES),
    .SLOT_BYTES(SLOT_BYTES), .UNPRIV_OFS(UNPRIV_OFS)
  ) u_vector (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_i),
    .kind_o(kind), .offset_o(offset)
  );

  pentry_commit #(.XLEN(XLEN), .SLOT_BYTES(SLOT_BYTES)) u_commit (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept_i),
    .kind_i(kind), .offset_i(offset), .base_i(base_i),
    .pc_i(pc_i), .mode_i(mode_i),
    .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o),
    .exc_addr_we_o(exc_addr_we_o), .exc_addr_o(exc_addr_o),
    .mode_set_o(mode_set_o), .swap_o(swap),
    .exc_clear_o(exc_clear_o), .abort_o(abort_o)
  );

  pentry_shadow_bank #(.XLEN(XLEN), .LANES(LANES)) u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .swap_i(swap),
    .load_i(arch_rdata_i), .shadow_o(arch_wdata_o)
  );

  assign arch_we_o = swap;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_idx
      assign swap_idx_o[k*REG_IDX_W +: REG_IDX_W] = lane_reg(k, LANES);
    end
  endgenerate

  AST_SWAP_WITH_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arch_we_o |-> (mode_set_o && pc_we_o)); // R4
endmodule

// File: tb/priv_entry_unit_tb.sv
module priv_entry_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         accept_i = 1'b0;
  logic [7:0]   code_i = '0;
  logic [63:0]  pc_i = '0;
  logic         mode_i = 1'b0;
  logic [63:0]  base_i = '0;
  logic [511:0] arch_rdata_i = '0;
  logic         pc_we_o, exc_addr_we_o, mode_set_o, exc_clear_o, abort_o, arch_we_o;
  logic [63:0]  pc_wdata_o, exc_addr_o;
  logic [511:0] arch_wdata_o;
  logic [39:0]  swap_idx_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [511:0] last_saved = '0;

  always #2 clk = ~clk;

  priv_entry_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .accept_i(accept_i), .code_i(code_i),
    .pc_i(pc_i), .mode_i(mode_i), .base_i(base_i), .arch_rdata_i(arch_rdata_i),
    .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o), .exc_addr_we_o(exc_addr_we_o),
    .exc_addr_o(exc_addr_o), .mode_set_o(mode_set_o), .exc_clear_o(exc_clear_o),
    .abort_o(abort_o), .arch_we_o(arch_we_o), .arch_wdata_o(arch_wdata_o),
    .swap_idx_o(swap_idx_o)
  );

  task automatic check(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] pattern(logic [63:0] seed);
    logic [511:0] p;
    for (int k = 0; k < 8; k++) p[k*64 +: 64] = seed ^ (64'h1111_0000_0000_0101 * 64'(k + 1));
    return p;
  endfunction

  // present one accept, check comb outputs, let the edge commit
  task automatic accept_one(logic [7:0] code, logic [63:0] pc, logic mode,
                            logic [63:0] base, logic [511:0] regs);
    logic good;
    logic [63:0] exp_pc;
    @(negedge clk);
    accept_i = 1'b1; code_i = code; pc_i = pc; mode_i = mode;
    base_i = base; arch_rdata_i = regs;
    #1;
    good = (code[6] == 1'b0);
    exp_pc = base + (code[7] ? 64'h2000 : 64'h0) + 64'(code[5:0]) * 64;
    if (good) begin
      check(code[7] ? "R2 pc_we" : "R1 pc_we", pc_we_o, 1);
      check(code[7] ? "R2 pc"    : "R1 pc", pc_wdata_o, exp_pc);
      check("R3 exc_we", exc_addr_we_o, 1);
      check("R3 exc_addr", exc_addr_o, pc | 64'(mode));
      check("R7 clear", exc_clear_o, 1);
      check("R6 no abort", abort_o, 0);
      if (!mode) begin
        check("R4 mode_set", mode_set_o, 1);
        check("R4 arch_we", arch_we_o, 1);
        check("R4 arch_wdata", arch_wdata_o, last_saved);
      end else begin
        check("R5 mode_set", mode_set_o, 0);
        check("R5 arch_we", arch_we_o, 0);
      end
    end else begin
      check("R6 abort", abort_o, 1);
      check("R6 pc_we", pc_we_o, 0);
      check("R6 exc_we", exc_addr_we_o, 0);
      check("R6 mode_set", mode_set_o, 0);
      check("R6 arch_we", arch_we_o, 0);
      check("R6 clear", exc_clear_o, 0);
    end
    if (good && !mode) last_saved = regs;
    @(negedge clk);
    accept_i = 1'b0;
    #1;
    check("R9 idle pc_we", pc_we_o, 0);
    check("R9 idle abort", abort_o, 0);
    check("R9 idle clear", exc_clear_o, 0);
  endtask

  task automatic t_reset;
    #1;
    check("R10 shadow zero after reset", arch_wdata_o, '0);
    check("R9 reset arch_we", arch_we_o, 0);
    for (int k = 0; k < 8; k++)
      check("R8 lane index", swap_idx_o[k*5 +: 5], (k == 7) ? 5'd25 : 5'(8 + k));
  endtask

  task automatic t_idle_normal;
    @(negedge clk);
    accept_i = 1'b0; mode_i = 1'b0; code_i = 8'h05; arch_rdata_i = pattern(64'hDEAD);
    #1;
    check("R9 no accept pc_we", pc_we_o, 0);
    check("R9 no accept mode_set", mode_set_o, 0);
    check("R9 no accept arch_we", arch_we_o, 0);
    @(negedge clk);
  endtask

  task automatic t_swaps_and_vectors;
    accept_one(8'h05, 64'h0000_1234_5678_9ABC, 1'b0, 64'h0000_0000_8000_0000, pattern(64'hA5A5_0000_0000_0001));
    accept_one(8'h83, 64'h0000_0000_0000_4000, 1'b1, 64'h0000_0000_8000_0000, pattern(64'hBAD0));
    accept_one(8'h40, 64'h0000_0000_0000_5000, 1'b0, 64'h0000_0000_8000_0000, pattern(64'hBAD1));
    accept_one(8'hC0, 64'h0000_0000_0000_5004, 1'b1, 64'h0000_0000_8000_0000, pattern(64'hBAD2));
    accept_one(8'h00, 64'h0000_0000_0000_6000, 1'b0, 64'h0000_0010_0000_0000, pattern(64'h5A5A_0000_0000_0002));
    accept_one(8'h3F, 64'h0000_0000_0000_7000, 1'b1, 64'h0000_0010_0000_0000, pattern(64'hBAD3));
    accept_one(8'h80, 64'h0000_0000_0000_7008, 1'b0, 64'h0000_0010_0000_0000, pattern(64'h0F0F_0000_0000_0003));
    accept_one(8'hBF, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 64'hFFFF_0000_0000_0000, pattern(64'hF0F0_0000_0000_0004));
    accept_one(8'h3F, 64'h0000_0000_0000_0100, 1'b0, 64'h0, pattern(64'h1234));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=<5000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    t_idle_normal;
    t_swaps_and_vectors;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule